// File: doc/BRIEF.md
# Normalizing and Denormalizing Barrel Shifter

This unit gives software-built floating-point code the raw pieces it needs: it finds the most significant bit of a 16-bit operand and moves it to the top of the word, and it can shift a value right to align it with a larger exponent. On a normalize the result register holds the shifted mantissa, and a separate exponent register holds the number of positions the value was moved. A denormalize command leaves that exponent register alone. It can take its shift amount from the command or reuse the exponent that a previous normalize left behind.

A 32-bit word is normalized in two back-to-back commands. The first command presents the upper half. The second presents the lower half and returns the upper 16 bits of the normalized 32-bit word, with the total shift count (0 to 31, or 32 for an all-zero word). A signed normalize mode counts redundant sign bits instead of leading zeros, so that two's-complement values keep their sign. Every command is accepted in one cycle, and its results appear on the registered outputs at the next clock edge.

Top module: `norm_shifter`

## Requirements
- R1: After reset, `res_out` is 0, `exp_out` is 0 and `zero_out` is 0.
- R2: A valid command with `cmd_op`=2'b00 and `cmd_hi`=1 on a nonzero operand sets `res_out` to the operand shifted left by its leading-zero count, and `exp_out` to that count (0..15) with `zero_out`=0. These values show on the outputs at the first rising edge after the command is sampled.
- R3: The same command on an all-zero operand gives `res_out`=0, `exp_out`=16 and `zero_out`=1.
- R4: A command with `cmd_op`=2'b00 and `cmd_hi`=0 issued while `exp_out` is below 16 presents the low half of a 32-bit word. Its output `res_out` is the upper 16 bits of {previous high half, low half} shifted left by `exp_out`, and `exp_out` is unchanged.
- R5: The same low-half command issued while `exp_out` is 16 or more normalizes the low half alone. `res_out` is the low half shifted by its own leading-zero count and `exp_out` is 16 plus that count. An all-zero low half gives `exp_out`=32, `res_out`=0 and `zero_out`=1.
- R6: `cmd_op`=2'b01 shifts the operand left by its count of redundant sign bits (leading bits equal to bit 15, minus one) and writes that count to `exp_out`. A nonzero result then has bits 15 and 14 different, except for the operand 16'hFFFF, which gives 16'h8000 with count 15. Zero gives `res_out`=0, `exp_out`=16 and `zero_out`=1. `cmd_hi` has no effect in this mode.
- R7: `cmd_op`=2'b10 shifts the operand right arithmetically by `cmd_shamt`. An amount of 16 or more gives all copies of bit 15. `zero_out` is set exactly when the result is 0, and `exp_out` is unchanged.
- R8: `cmd_op`=2'b11 behaves like 2'b10 but takes the shift amount from the current `exp_out` and ignores `cmd_shamt`. `exp_out` is unchanged.
- R9: While `cmd_valid` is low, `res_out`, `exp_out` and `zero_out` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | 00 normalize, 01 signed normalize, 10 right shift by `cmd_shamt`, 11 right shift by `exp_out` |
| cmd_hi | input | 1 | Normalize only: 1 for a single word or the upper half, 0 for the lower half of a 32-bit word |
| cmd_data | input | WIDTH (16) | Operand |
| cmd_shamt | input | EXP_W (6) | Right-shift amount for op 10 |
| res_out | output | WIDTH (16) | Shifted result register |
| exp_out | output | EXP_W (6) | Exponent register |
| zero_out | output | 1 | Zero-operand / zero-result flag |

## Verification
The exponent register feeds back into both the two-step normalize and the shift-by-exponent command. A wrong count therefore shows up twice: once on `exp_out` in the cycle after the normalize, and again one command later as a misaligned mantissa or denormalized value. A low-half step that takes the wrong path (merge or fresh count) shows on the very next edge as an exponent that either moved when it should have stayed, or stayed below 16 when it should have grown. Hold failures are visible at once as an output that changes on an edge with `cmd_valid` low.

// File: rtl/ns_pkg.sv
package ns_pkg;
   typedef enum logic [1:0] {
      OP_NORM    = 2'b00,
      OP_SNORM   = 2'b01,
      OP_SHR     = 2'b10,
      OP_SHR_EXP = 2'b11
   } ns_op_e;
endpackage

// File: rtl/ns_lzc.sv
// Leading-zero counter; an all-zero input reports W.
module ns_lzc #(
   parameter int W  = 16,
   parameter int CW = $clog2(W) + 1
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);
   if (CW < $clog2(W) + 1) begin : g_bad_cw
      $error("ns_lzc: CW too narrow for W");
   end

   always_comb begin
      logic found;
      found = 1'b0;
      cnt   = CW'(W);
      for (int i = W - 1; i >= 0; i--) begin
         if (!found && vec[i]) begin
            cnt   = CW'(W - 1 - i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ns_shl.sv
// Logarithmic left shifter; amounts of W or more give zero.
module ns_shl #(
   parameter int W  = 16,
   parameter int AW = $clog2(W) + 2
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);
   localparam int ST = $clog2(W);

   if (AW < ST + 1) begin : g_bad_aw
      $error("ns_shl: AW cannot express W");
   end

   logic [W-1:0] stg [ST+1];
   assign stg[0] = din;

   for (genvar s = 0; s < ST; s++) begin : g_stage
      assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
   end

   assign dout = (amt >= AW'(W)) ? '0 : stg[ST];
endmodule

// File: rtl/ns_shr.sv
// Logarithmic right shifter with a fill bit; amounts of W or more give all fill.
module ns_shr #(
   parameter int W  = 16,
   parameter int AW = $clog2(W) + 2
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   input  logic          fill,
   output logic [W-1:0]  dout
);
   localparam int ST = $clog2(W);

   if (AW < ST + 1) begin : g_bad_aw
      $error("ns_shr: AW cannot express W");
   end

   logic [W-1:0] stg [ST+1];
   assign stg[0] = din;

   for (genvar s = 0; s < ST; s++) begin : g_stage
      assign stg[s+1] = amt[s] ? {{(1 << s){fill}}, stg[s][W-1:(1 << s)]} : stg[s];
   end

   assign dout = (amt >= AW'(W)) ? {W{fill}} : stg[ST];
endmodule

// File: rtl/norm_shifter.sv
module norm_shifter
   import ns_pkg::*;
#(
   parameter  int WIDTH = 16,
   localparam int EXP_W = $clog2(2 * WIDTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic             cmd_hi,
   input  logic [WIDTH-1:0] cmd_data,
   input  logic [EXP_W-1:0] cmd_shamt,
   output logic [WIDTH-1:0] res_out,
   output logic [EXP_W-1:0] exp_out,
   output logic             zero_out
);
   localparam int CNT_W = $clog2(WIDTH) + 1;
   localparam logic [EXP_W-1:0] WORD_EXP = EXP_W'(WIDTH);

   if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("norm_shifter: WIDTH must be a power of two, at least 4");
   end

   ns_op_e op;
   assign op = ns_op_e'(cmd_op);

   logic [WIDTH-1:0] res_q, res_d;
   logic [EXP_W-1:0] exp_q, exp_d;
   logic             zero_q, zero_d;

   // leading-zero count and redundant-sign count of the operand
   logic [CNT_W-1:0] lz_cnt, rs_cnt;
   logic [WIDTH-1:0] rs_vec;
   assign rs_vec = {cmd_data[WIDTH-1:1] ^ cmd_data[WIDTH-2:0], 1'b1};

   ns_lzc #(.W(WIDTH), .CW(CNT_W)) u_lz (.vec(cmd_data), .cnt(lz_cnt));
   ns_lzc #(.W(WIDTH), .CW(CNT_W)) u_rs (.vec(rs_vec),   .cnt(rs_cnt));

   logic [EXP_W-1:0] lz_ext, rs_ext;
   assign lz_ext = EXP_W'(lz_cnt);
   assign rs_ext = EXP_W'(rs_cnt);

   logic data_zero, chain_merge;
   assign data_zero   = (cmd_data == '0);
   assign chain_merge = (op == OP_NORM) && !cmd_hi && (exp_q < WORD_EXP);

   // one left shifter for both normalize flavours
   logic [EXP_W-1:0] shl_amt;
   logic [WIDTH-1:0] shl_out;
   assign shl_amt = (op == OP_SNORM) ? rs_ext : lz_ext;
   ns_shl #(.W(WIDTH), .AW(EXP_W)) u_shl (.din(cmd_data), .amt(shl_amt), .dout(shl_out));

   // one right shifter for denormalize and for the low-half merge
   logic [EXP_W-1:0] shr_amt;
   logic             shr_fill;
   logic [WIDTH-1:0] shr_out;
   always_comb begin
      if (chain_merge) begin
         shr_amt  = WORD_EXP - exp_q;
         shr_fill = 1'b0;
      end else begin
         shr_amt  = (op == OP_SHR_EXP) ? exp_q : cmd_shamt;
         shr_fill = cmd_data[WIDTH-1];
      end
   end
   ns_shr #(.W(WIDTH), .AW(EXP_W)) u_shr (.din(cmd_data), .amt(shr_amt), .fill(shr_fill), .dout(shr_out));

   always_comb begin
      res_d  = res_q;
      exp_d  = exp_q;
      zero_d = zero_q;
      unique case (op)
         OP_NORM: begin
            if (cmd_hi) begin
               res_d  = shl_out;
               exp_d  = lz_ext;
               zero_d = data_zero;
            end else if (chain_merge) begin
               res_d  = res_q | shr_out;
               zero_d = ~|(res_q | shr_out);
            end else begin
               res_d  = shl_out;
               exp_d  = WORD_EXP + lz_ext;
               zero_d = data_zero;
            end
         end
         OP_SNORM: begin
            res_d  = shl_out;
            exp_d  = data_zero ? WORD_EXP : rs_ext;
            zero_d = data_zero;
         end
         OP_SHR, OP_SHR_EXP: begin
            res_d  = shr_out;
            zero_d = ~|shr_out;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         exp_q  <= '0;
         zero_q <= 1'b0;
      end else if (cmd_valid) begin
         res_q  <= res_d;
         exp_q  <= exp_d;
         zero_q <= zero_d;
      end
   end

   assign res_out  = res_q;
   assign exp_out  = exp_q;
   assign zero_out = zero_q;

   // ---------------------------------------------------------------
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(res_out) && $stable(exp_out) && $stable(zero_out));

   p_norm_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && op == OP_NORM && cmd_hi && cmd_data != '0
      |=> res_out[WIDTH-1] && exp_out < WORD_EXP && !zero_out);

   p_zero_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && op == OP_NORM && cmd_hi && cmd_data == '0
      |=> zero_out && res_out == '0 && exp_out == WORD_EXP);

   p_merge_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && op == OP_NORM && !cmd_hi && exp_out < WORD_EXP
      |=> $stable(exp_out));

   p_low_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && op == OP_NORM && !cmd_hi && exp_out >= WORD_EXP
      |=> exp_out >= WORD_EXP);

   p_sign_norm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && op == OP_SNORM && cmd_data != '0
      |=> (res_out[WIDTH-1] != res_out[WIDTH-2]) || res_out == {1'b1, {(WIDTH-1){1'b0}}});

   p_shr_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && op == OP_SHR
      |=> res_out[WIDTH-1] == $past(cmd_data[WIDTH-1]) && $stable(exp_out));

   p_shr_exp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && op == OP_SHR_EXP
      |=> $stable(exp_out) && res_out[WIDTH-1] == $past(cmd_data[WIDTH-1]));
endmodule

// File: tb/test_norm_shifter.sv
`timescale 1ns/1ps
module test_norm_shifter;
   localparam int W  = 16;
   localparam int EW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic          cmd_hi = 1'b0;
   logic [W-1:0]  cmd_data = '0;
   logic [EW-1:0] cmd_shamt = '0;
   logic [W-1:0]  res_out;
   logic [EW-1:0] exp_out;
   logic          zero_out;

   always #2.5 clk = ~clk;

   norm_shifter #(.WIDTH(W)) i_norm_shifter (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_hi(cmd_hi), .cmd_data(cmd_data), .cmd_shamt(cmd_shamt),
      .res_out(res_out), .exp_out(exp_out), .zero_out(zero_out));

   int total = 0;
   int bad   = 0;

   typedef struct packed {
      logic [1:0]    op;
      logic          hi;
      logic [W-1:0]  data;
      logic [EW-1:0] sh;
      logic [W-1:0]  res;
      logic [EW-1:0] ex;
      logic          z;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 1'b1, 16'h0001, 6'd0,  16'h8000, 6'd15, 1'b0, 4'd2}, // R2
      '{2'b00, 1'b1, 16'h8000, 6'd0,  16'h8000, 6'd0,  1'b0, 4'd2}, // R2
      '{2'b00, 1'b1, 16'h00F3, 6'd0,  16'hF300, 6'd8,  1'b0, 4'd2}, // R2
      '{2'b00, 1'b1, 16'h0000, 6'd0,  16'h0000, 6'd16, 1'b1, 4'd3}, // R3
      '{2'b00, 1'b1, 16'h0012, 6'd0,  16'h9000, 6'd11, 1'b0, 4'd2}, // R2 high half
      '{2'b00, 1'b0, 16'hABCD, 6'd0,  16'h955E, 6'd11, 1'b0, 4'd4}, // R4 merge
      '{2'b00, 1'b1, 16'h8001, 6'd0,  16'h8001, 6'd0,  1'b0, 4'd2}, // R2
      '{2'b00, 1'b0, 16'hFFFF, 6'd0,  16'h8001, 6'd0,  1'b0, 4'd4}, // R4 shift 0
      '{2'b00, 1'b1, 16'h0000, 6'd0,  16'h0000, 6'd16, 1'b1, 4'd3}, // R3
      '{2'b00, 1'b0, 16'h0300, 6'd0,  16'hC000, 6'd22, 1'b0, 4'd5}, // R5
      '{2'b00, 1'b1, 16'h0000, 6'd0,  16'h0000, 6'd16, 1'b1, 4'd3}, // R3
      '{2'b00, 1'b0, 16'h0000, 6'd0,  16'h0000, 6'd32, 1'b1, 4'd5}, // R5 all zero
      '{2'b00, 1'b1, 16'h0000, 6'd0,  16'h0000, 6'd16, 1'b1, 4'd3}, // R3
      '{2'b00, 1'b0, 16'h8000, 6'd0,  16'h8000, 6'd16, 1'b0, 4'd5}, // R5
      '{2'b01, 1'b1, 16'h0003, 6'd0,  16'h6000, 6'd13, 1'b0, 4'd6}, // R6
      '{2'b01, 1'b0, 16'hFFF0, 6'd0,  16'h8000, 6'd11, 1'b0, 4'd6}, // R6 hi ignored
      '{2'b01, 1'b1, 16'hFFFF, 6'd0,  16'h8000, 6'd15, 1'b0, 4'd6}, // R6 minus one
      '{2'b01, 1'b1, 16'h0000, 6'd0,  16'h0000, 6'd16, 1'b1, 4'd6}, // R6 zero
      '{2'b01, 1'b1, 16'hC123, 6'd0,  16'h8246, 6'd1,  1'b0, 4'd6}, // R6
      '{2'b01, 1'b0, 16'h4000, 6'd0,  16'h4000, 6'd0,  1'b0, 4'd6}, // R6
      '{2'b10, 1'b0, 16'h8000, 6'd4,  16'hF800, 6'd0,  1'b0, 4'd7}, // R7
      '{2'b10, 1'b1, 16'h7FF0, 6'd4,  16'h07FF, 6'd0,  1'b0, 4'd7}, // R7
      '{2'b10, 1'b0, 16'h0001, 6'd1,  16'h0000, 6'd0,  1'b1, 4'd7}, // R7 zero flag
      '{2'b10, 1'b0, 16'h8000, 6'd16, 16'hFFFF, 6'd0,  1'b0, 4'd7}, // R7 saturate
      '{2'b10, 1'b0, 16'h7FFF, 6'd40, 16'h0000, 6'd0,  1'b1, 4'd7}, // R7 saturate
      '{2'b10, 1'b0, 16'h1234, 6'd0,  16'h1234, 6'd0,  1'b0, 4'd7}, // R7 zero amount
      '{2'b00, 1'b1, 16'h0010, 6'd0,  16'h8000, 6'd11, 1'b0, 4'd2}, // R2
      '{2'b11, 1'b0, 16'h8000, 6'd0,  16'hFFF0, 6'd11, 1'b0, 4'd8}, // R8
      '{2'b11, 1'b0, 16'h4000, 6'd63, 16'h0008, 6'd11, 1'b0, 4'd8}, // R8 shamt ignored
      '{2'b00, 1'b1, 16'h0000, 6'd0,  16'h0000, 6'd16, 1'b1, 4'd3}, // R3
      '{2'b11, 1'b0, 16'h7FFF, 6'd0,  16'h0000, 6'd16, 1'b1, 4'd8}  // R8 full width
   };

   task automatic expect_out(input string req, input logic [W-1:0] r,
                             input logic [EW-1:0] e, input logic z);
      total++;
      if (res_out !== r || exp_out !== e || zero_out !== z) begin
         bad++;
         $display("FAIL %s: res=%h exp=%0d zero=%b, expected res=%h exp=%0d zero=%b",
                  req, res_out, exp_out, zero_out, r, e, z);
      end
   endtask

   // drive at a falling edge, capture on the rising edge, return at the next falling edge
   task automatic issue(input logic [1:0] op, input logic hi,
                        input logic [W-1:0] d, input logic [EW-1:0] sh);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_hi    = hi;
      cmd_data  = d;
      cmd_shamt = sh;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_out("R1 in reset", 16'h0000, 6'd0, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      expect_out("R1 after release", 16'h0000, 6'd0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].op, VECS[i].hi, VECS[i].data, VECS[i].sh);
         expect_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                    VECS[i].res, VECS[i].ex, VECS[i].z);
      end

      // R9: idle cycles with changing inputs must leave the registers alone
      issue(2'b00, 1'b1, 16'h0104, 6'd0);
      expect_out("R2 before hold", 16'h8200, 6'd7, 1'b0);
      for (int k = 0; k < 4; k++) begin
         cmd_op   = 2'(k);
         cmd_hi   = k[0];
         cmd_data = 16'h0000;
         cmd_shamt = 6'(k * 9);
         @(negedge clk);
         expect_out("R9 hold", 16'h8200, 6'd7, 1'b0);
      end

      // R2: result appears exactly one edge after the command, not before
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b00; cmd_hi = 1'b1; cmd_data = 16'h0001;
      #1;
      expect_out("R2 not before edge", 16'h8200, 6'd7, 1'b0);
      @(negedge clk);
      cmd_valid = 1'b0;
      expect_out("R2 after one edge", 16'h8000, 6'd15, 1'b0);

      // R8 after an R4 merge: exponent from the two-step normalize drives the shift
      issue(2'b00, 1'b1, 16'h0001, 6'd0);
      issue(2'b00, 1'b0, 16'h4000, 6'd0);
      expect_out("R4 merge bit", 16'hA000, 6'd15, 1'b0);
      issue(2'b11, 1'b1, 16'hA000, 6'd1);
      expect_out("R8 by 15", 16'hFFFF, 6'd15, 1'b0);

      // R1: reset in the middle of operation
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      expect_out("R1 mid-run reset", 16'h0000, 6'd0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule